// File: doc/BRIEF.md
# Network Activity LED Driver

This block drives a single status LED for an Ethernet controller. Each network event source has its own enable bit in a 16-bit software register: collision, any receive, transmit, address-matched receive, link pass, full-duplex link pass, and magic-packet detection. The LED is lit whenever any enabled source is active. Software reads the same register back, and its top bit shows the live LED state.

An optional retriggerable stretcher keeps short activity strobes visible. When the stretch enable is set, every new rising edge of an enabled pulsed source (collision, receive, transmit, matched receive) lights the LED for a fixed number of clock cycles. A fresh edge during that time starts the full count again. Level sources (link, full-duplex link, magic packet) keep the LED lit for as long as they are true.

A hard reset loads the register defaults. A soft reset or the stop control leaves the enables untouched and only darkens the LED and its timer. The MAC, PHY, address filter and host bus are outside this block. They appear here only as input strobes and levels.

Top module: `netled_drv`

## Requirements
- R1: While `hrst_n` is low and after it is released, `rd_data` reads 0x0084 (stretch enable bit 7 and receive enable bit 2 set, all else clear) and `led_o` is 0.
- R2: Bits 1, 3, 10, 11, 12, 13 and 14 of the register ignore writes and always read 0. A write of 0xFFFF reads back as 0x03F5 while the LED is dark.
- R3: `rd_data[15]` always equals `led_o`, and writes to bit 15 have no effect.
- R4: The enable bit positions are: collision bit 0, receive bit 2, transmit bit 4, matched receive bit 5, link bit 6, full-duplex link bit 8, magic packet bit 9. A source whose enable is clear never lights the LED.
- R5: With bit 7 clear, `led_o` equals the OR of all enabled sources, as sampled at the previous clock edge.
- R6: With bit 7 set, a rising edge of an enabled pulsed source lights `led_o` from the next edge for exactly `STRETCH_CYC` cycles, even if the pulse lasts one cycle.
- R7: A new rising edge during the lit time restarts the full `STRETCH_CYC` count from that edge.
- R8: An enabled link source keeps `led_o` at 1 for as long as it is true, in both modes, and adds no stretch when it falls.
- R9: `srst` and `stop_i` leave all enable bits unchanged.
- R10: A cycle with `srst` or `stop_i` high sets `led_o` to 0 at the next edge and discards any remaining stretch time.
- R11: The full-duplex source is active only while both `lnk_ok` and `fdx_on` are 1. The magic-packet source is active only while both `mp_mode` and `mp_seen` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hrst_n | input | 1 | Hard reset, asynchronous, active low; loads register defaults |
| srst | input | 1 | Soft reset, synchronous, active high; keeps enables |
| stop_i | input | 1 | Controller stop; darkens LED, keeps enables |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value, bit 15 = live LED state |
| ev_col | input | 1 | Collision activity strobe |
| ev_rx | input | 1 | Receive activity strobe |
| ev_tx | input | 1 | Transmit activity strobe |
| ev_rxmatch | input | 1 | Receive activity that passed any address match mode |
| lnk_ok | input | 1 | Link pass level |
| fdx_on | input | 1 | Full-duplex operation level |
| mp_mode | input | 1 | Magic-packet mode enabled level |
| mp_seen | input | 1 | Magic-packet frame detected level |
| led_o | output | 1 | Registered LED drive, active high |

## Verification
With the stretcher off, the bench sweeps all 256 combinations of the eight event inputs under several enable masks. Each mask lights a different subset, so this separates a wrong bit position from a missing enable gate and from the two-input conditions of the full-duplex and magic-packet sources. With the stretcher on, single-cycle strobes measure the exact lit length. A second strobe placed three cycles later tells a restarting timer apart from one that only extends or ignores the retrigger. A strobe on a disabled source must leave the LED dark. Soft reset, stop, writes of all ones and a mid-run hard reset complete the picture of what the register keeps and what it loses.

// File: rtl/netled_pkg.sv
package netled_pkg;
    localparam int REG_W  = 16;
    localparam int NPULSE = 4;

    // Enable bit positions decoded by software
    localparam int B_COL = 0;
    localparam int B_RX  = 2;
    localparam int B_TX  = 4;
    localparam int B_RXM = 5;
    localparam int B_LNK = 6;
    localparam int B_STR = 7;
    localparam int B_FDX = 8;
    localparam int B_MPK = 9;
    localparam int B_LED = 15;

    // Pulsed sources that may retrigger the stretcher
    localparam int PULSE_POS [NPULSE] = '{B_COL, B_RX, B_TX, B_RXM};

    localparam logic [REG_W-1:0] WR_MASK  = (REG_W'(1) << B_COL) | (REG_W'(1) << B_RX)
                                          | (REG_W'(1) << B_TX)  | (REG_W'(1) << B_RXM)
                                          | (REG_W'(1) << B_LNK) | (REG_W'(1) << B_STR)
                                          | (REG_W'(1) << B_FDX) | (REG_W'(1) << B_MPK);
    localparam logic [REG_W-1:0] CFG_DFLT = (REG_W'(1) << B_STR) | (REG_W'(1) << B_RX);
endpackage

// File: rtl/netled_cfg.sv
module netled_cfg
    import netled_pkg::*;
(
    input  logic             clk,
    input  logic             hrst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] en_o
);
    typedef struct packed {
        logic [REG_W-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.en = wr_data & WR_MASK;
        end
    end

    // Only the hard reset touches the enables
    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            cfg_q.en <= CFG_DFLT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o = cfg_q.en;
endmodule

// File: rtl/netled_src.sv
module netled_src
    import netled_pkg::*;
(
    input  logic [REG_W-1:0]  en_i,
    input  logic              ev_col,
    input  logic              ev_rx,
    input  logic              ev_tx,
    input  logic              ev_rxmatch,
    input  logic              lnk_ok,
    input  logic              fdx_on,
    input  logic              mp_mode,
    input  logic              mp_seen,
    output logic              raw_o,
    output logic [NPULSE-1:0] pls_o
);
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] masked;

    always_comb begin
        src        = '0;
        src[B_COL] = ev_col;
        src[B_RX]  = ev_rx;
        src[B_TX]  = ev_tx;
        src[B_RXM] = ev_rxmatch;
        src[B_LNK] = lnk_ok;
        src[B_FDX] = lnk_ok & fdx_on;
        src[B_MPK] = mp_mode & mp_seen;
    end

    assign masked = src & en_i;
    assign raw_o  = |masked;

    for (genvar i = 0; i < NPULSE; i++) begin : g_pulse
        assign pls_o[i] = masked[PULSE_POS[i]];
    end
endmodule

// File: rtl/netled_stretch.sv
module netled_stretch
    import netled_pkg::*;
#(
    parameter int STRETCH_CYC = 4_000_000
) (
    input  logic              clk,
    input  logic              hrst_n,
    input  logic              clr_i,
    input  logic              stretch_en,
    input  logic              raw_i,
    input  logic [NPULSE-1:0] pls_i,
    output logic              led_o
);
    localparam int CNT_W = (STRETCH_CYC < 2) ? 1 : $clog2(STRETCH_CYC);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [NPULSE-1:0] prev;
        logic              led;
    } st_t;

    st_t  st_d, st_q;
    logic trig;

    always_comb begin
        st_d      = st_q;
        trig      = |(pls_i & ~st_q.prev);
        st_d.prev = pls_i;
        if (!stretch_en) begin
            st_d.cnt = '0;
        end else if (trig) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.led = raw_i | (stretch_en && (st_q.cnt != '0));
        if (clr_i) begin
            st_d.cnt  = '0;
            st_d.prev = '0;
            st_d.led  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign led_o = st_q.led;
endmodule

// File: rtl/netled_drv.sv
module netled_drv
    import netled_pkg::*;
#(
    parameter int STRETCH_CYC = 4_000_000
) (
    input  logic        clk,
    input  logic        hrst_n,
    input  logic        srst,
    input  logic        stop_i,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        ev_col,
    input  logic        ev_rx,
    input  logic        ev_tx,
    input  logic        ev_rxmatch,
    input  logic        lnk_ok,
    input  logic        fdx_on,
    input  logic        mp_mode,
    input  logic        mp_seen,
    output logic        led_o
);
    logic [REG_W-1:0]  en;
    logic              raw;
    logic [NPULSE-1:0] pls;
    logic              led;

    netled_cfg u_cfg (
        .clk     (clk),
        .hrst_n  (hrst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .en_o    (en)
    );

    netled_src u_src (
        .en_i       (en),
        .ev_col     (ev_col),
        .ev_rx      (ev_rx),
        .ev_tx      (ev_tx),
        .ev_rxmatch (ev_rxmatch),
        .lnk_ok     (lnk_ok),
        .fdx_on     (fdx_on),
        .mp_mode    (mp_mode),
        .mp_seen    (mp_seen),
        .raw_o      (raw),
        .pls_o      (pls)
    );

    netled_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_str (
        .clk        (clk),
        .hrst_n     (hrst_n),
        .clr_i      (srst | stop_i),
        .stretch_en (en[B_STR]),
        .raw_i      (raw),
        .pls_i      (pls),
        .led_o      (led)
    );

    assign led_o   = led;
    assign rd_data = {led, en[B_LED-1:0]};
endmodule

// File: rtl/netled_chk.sv
module netled_chk (
    input logic        clk,
    input logic        hrst_n,
    input logic        srst,
    input logic        stop_i,
    input logic        wr_en,
    input logic [15:0] rd_data,
    input logic        ev_col,
    input logic        ev_rx,
    input logic        ev_tx,
    input logic        ev_rxmatch,
    input logic        lnk_ok,
    input logic        fdx_on,
    input logic        mp_mode,
    input logic        mp_seen,
    input logic        led_o
);
    logic any_src;
    assign any_src = (ev_col & rd_data[0]) | (ev_rx & rd_data[2]) | (ev_tx & rd_data[4])
                   | (ev_rxmatch & rd_data[5]) | (lnk_ok & rd_data[6])
                   | (lnk_ok & fdx_on & rd_data[8]) | (mp_mode & mp_seen & rd_data[9]);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!hrst_n)
        (rd_data[14:10] == 5'd0) && !rd_data[3] && !rd_data[1]); // R2

    AST_STRETCH_OFF: assert property (@(posedge clk) disable iff (!hrst_n)
        (!rd_data[7] && !srst && !stop_i) |=> (led_o == $past(any_src))); // R5

    AST_NEW_EDGE: assert property (@(posedge clk) disable iff (!hrst_n)
        (rd_data[7] && rd_data[0] && ev_col && !$past(ev_col) && !srst && !stop_i) |=> led_o); // R6

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!hrst_n)
        (rd_data[6] && lnk_ok && !srst && !stop_i) |=> led_o); // R8

    AST_ENABLES_KEPT: assert property (@(posedge clk) disable iff (!hrst_n)
        ((srst || stop_i) && !wr_en) |=> (rd_data[14:0] == $past(rd_data[14:0]))); // R9

    AST_CLR_DARK: assert property (@(posedge clk) disable iff (!hrst_n)
        (srst || stop_i) |=> !led_o); // R10
endmodule

bind netled_drv netled_chk chk_i (
    .clk        (clk),
    .hrst_n     (hrst_n),
    .srst       (srst),
    .stop_i     (stop_i),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .ev_col     (ev_col),
    .ev_rx      (ev_rx),
    .ev_tx      (ev_tx),
    .ev_rxmatch (ev_rxmatch),
    .lnk_ok     (lnk_ok),
    .fdx_on     (fdx_on),
    .mp_mode    (mp_mode),
    .mp_seen    (mp_seen),
    .led_o      (led_o)
);

// File: tb/netled_drv_tb.sv
module netled_drv_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 5;

    logic        clk = 1'b0;
    logic        hrst_n, srst, stop_i, wr_en;
    logic [15:0] wr_data, rd_data;
    logic        ev_col, ev_rx, ev_tx, ev_rxmatch, lnk_ok, fdx_on, mp_mode, mp_seen;
    logic        led_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    netled_drv #(.STRETCH_CYC(N)) dut_i (
        .clk(clk), .hrst_n(hrst_n), .srst(srst), .stop_i(stop_i),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_col(ev_col), .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_rxmatch(ev_rxmatch),
        .lnk_ok(lnk_ok), .fdx_on(fdx_on), .mp_mode(mp_mode), .mp_seen(mp_seen),
        .led_o(led_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ev(input logic [7:0] p);
        {mp_seen, mp_mode, fdx_on, lnk_ok, ev_rxmatch, ev_tx, ev_rx, ev_col} = p;
    endtask

    task automatic wr(input logic [15:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic logic expect_led(input logic [15:0] m, input logic [7:0] p);
        logic r;
        r = 1'b0;
        if (m[0] && p[0]) r = 1'b1;
        if (m[2] && p[1]) r = 1'b1;
        if (m[4] && p[2]) r = 1'b1;
        if (m[5] && p[3]) r = 1'b1;
        if (m[6] && p[4]) r = 1'b1;
        if (m[8] && p[4] && p[5]) r = 1'b1;
        if (m[9] && p[6] && p[7]) r = 1'b1;
        return r;
    endfunction

    initial begin
        logic [15:0] masks [5];
        masks = '{16'h0000, 16'h0375, 16'h0015, 16'h0360, 16'h0141};
        hrst_n = 1'b0; srst = 1'b0; stop_i = 1'b0; wr_en = 1'b0; wr_data = '0;
        set_ev(8'h00);
        tick(); tick();
        chk("R1 reset value during reset", rd_data, 16'h0084);
        chk("R1 led during reset", {15'd0, led_o}, 16'd0);
        hrst_n = 1'b1;
        tick();
        chk("R1 reset value after release", rd_data, 16'h0084);

        // R2 and R3: reserved bits and bit 15
        wr(16'hFFFF); tick();
        chk("R2 reserved bits read zero", rd_data, 16'h03F5);
        wr(16'h0000); tick();
        chk("R2 all clear", rd_data, 16'h0000);

        // R4 R5 R11 R3: stretch off, exhaustive input sweep
        foreach (masks[mi]) begin
            wr(masks[mi]);
            for (int p = 0; p < 256; p++) begin
                set_ev(8'(p));
                tick();
                chk("R5 R4 R11 led vs enabled sources", {15'd0, led_o},
                    {15'd0, expect_led(masks[mi], 8'(p))});
                chk("R3 bit15 mirrors led", {15'd0, rd_data[15]},
                    {15'd0, expect_led(masks[mi], 8'(p))});
            end
            set_ev(8'h00);
        end

        // R6: single strobe lit for exactly N cycles
        wr(16'h0081); tick(); tick();
        ev_col = 1'b1; tick();
        chk("R6 first lit cycle", {15'd0, led_o}, 16'd1);
        ev_col = 1'b0;
        for (int k = 1; k < N; k++) begin
            tick();
            chk("R6 stretched on-time", {15'd0, led_o}, 16'd1);
        end
        tick();
        chk("R6 dark after N cycles", {15'd0, led_o}, 16'd0);

        // R7: retrigger three cycles after first edge
        tick();
        ev_col = 1'b1; tick();
        ev_col = 1'b0; tick(); tick();
        ev_col = 1'b1; tick();
        ev_col = 1'b0;
        for (int k = 1; k < N; k++) begin
            tick();
            chk("R7 restarted on-time", {15'd0, led_o}, 16'd1);
        end
        tick();
        chk("R7 dark after restarted count", {15'd0, led_o}, 16'd0);

        // R4: disabled pulsed source in stretch mode
        ev_tx = 1'b1; tick(); ev_tx = 1'b0;
        chk("R4 disabled transmit strobe", {15'd0, led_o}, 16'd0);
        for (int k = 0; k < N; k++) begin
            tick();
            chk("R4 disabled strobe stays dark", {15'd0, led_o}, 16'd0);
        end

        // R8: level source holds, no tail
        wr(16'h00C0);
        lnk_ok = 1'b1;
        for (int k = 0; k < 3 * N; k++) begin
            tick();
            chk("R8 link holds led", {15'd0, led_o}, 16'd1);
        end
        lnk_ok = 1'b0; tick();
        chk("R8 no tail after link drop", {15'd0, led_o}, 16'd0);

        // R10: soft reset and stop darken and discard stretch
        wr(16'h0081); tick();
        ev_col = 1'b1; tick();
        ev_col = 1'b0; srst = 1'b1; tick();
        chk("R10 soft reset darkens", {15'd0, led_o}, 16'd0);
        srst = 1'b0; tick();
        chk("R10 stretch discarded after soft reset", {15'd0, led_o}, 16'd0);
        ev_col = 1'b1; tick();
        ev_col = 1'b0; stop_i = 1'b1; tick();
        chk("R10 stop darkens", {15'd0, led_o}, 16'd0);
        stop_i = 1'b0; tick();
        chk("R10 stretch discarded after stop", {15'd0, led_o}, 16'd0);

        // R9: enables survive soft reset and stop
        wr(16'h03F5);
        srst = 1'b1; tick(); srst = 1'b0; tick();
        chk("R9 enables kept over soft reset", rd_data, 16'h03F5);
        stop_i = 1'b1; tick(); tick(); stop_i = 1'b0; tick();
        chk("R9 enables kept over stop", rd_data, 16'h03F5);

        // R1: hard reset mid-run restores defaults
        wr(16'h0000);
        hrst_n = 1'b0; tick();
        hrst_n = 1'b1; tick();
        chk("R1 defaults after mid-run hard reset", rd_data, 16'h0084);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule